// File: doc/BRIEF.md
# Segmented Cartridge Image Loader

The loader accepts a cartridge image one byte at a time and writes the 16-bit words it carries into a 64K-word memory. The image opens with a three-byte header: a fixed marker byte, a segment count, and a guard byte that must be the bitwise inverse of the count. Each segment follows as a pair of upper-address bytes, the word data, and a big-endian CRC-16 computed over that segment.

After the last segment comes a 48-byte attribute table followed by its own CRC. The table is only verified here; nothing is written to memory for it.

The loader stops at the first fault it finds and holds its error flag until reset. The done flag rises only after the attribute table checks out. Upstream logic streams bytes over a valid/ready handshake. The memory write port is a one-cycle strobe with address and data, and input ready is dropped during that cycle.

Top module: `cart_image_loader`

## Requirements
- R1: The first byte must be 0xA8 and the third byte must equal the second byte (the segment count) XORed with 0xFF; either mismatch raises `error`.
- R2: A segment's first two bytes are the start and end upper-address bytes. Words are written at consecutive addresses from start_hi*256 up to end_hi*256+255 inclusive, each word formed from a high byte followed by a low byte.
- R3: A segment whose end upper byte is smaller than its start upper byte raises `error`, and no word of that segment is written.
- R4: Each segment's CRC uses polynomial 0x1021, is processed MSB first, and is initialised to 0xFFFF. It covers both range bytes and every data byte. The next two bytes, high byte first, must match it, otherwise `error` is raised.
- R5: After the segments, 48 attribute bytes are hashed with the same CRC, again starting from 0xFFFF, and compared against the next two bytes, high byte first. `done` rises only on a match; a mismatch raises `error`.
- R6: On the first fault the loader stops: `in_ready` stays low, no further writes occur, `error` holds until reset, and `done` never rises.
- R7: Each word is written with exactly one single-cycle `wr_en` pulse, and `in_ready` is low in that cycle.
- R8: After reset `in_ready` is high and `wr_en`, `done` and `error` are low.
- R9: A segment count of zero passes directly from the header to the attribute table.
- R10: Once `done` is high it stays high, `in_ready` stays low and no writes occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Image byte |
| in_valid | input | 1 | `in_byte` is valid |
| in_ready | output | 1 | Loader takes `in_byte` this cycle when valid |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory word address |
| wr_data | output | 16 | Memory word data |
| done | output | 1 | Image loaded and attribute CRC matched |
| error | output | 1 | Sticky fault flag |

## Verification
The bench builds the loader with its default parameters: a 16-bit word address and a 48-byte attribute table. With these defaults a segment can run up to word 0xFFFF, so the top-of-memory boundary of the address walker is exercised without any address wrap. Segments of one and two 256-word pages let the bench compare the full write sequence against its own CRC and data model. Separate images place a fault in the header, the range, the segment CRC and the attribute CRC.

// File: rtl/cil_pkg.sv
`timescale 1ns/1ps
package cil_pkg;

  typedef enum logic [3:0] {
    ST_MARK, ST_COUNT, ST_GUARD,
    ST_RSTART, ST_REND, ST_DHI, ST_DLO, ST_WRITE,
    ST_CHI, ST_CLO,
    ST_ATTR, ST_AHI, ST_ALO,
    ST_DONE, ST_FAIL
  } ld_state_e;

  // One byte through a bitwise MSB-first CRC-16
  function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/cil_crc_unit.sv
`timescale 1ns/1ps
module cil_crc_unit import cil_pkg::*; #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        update,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= INIT;
    else if (clear)  crc <= INIT;
    else if (update) crc <= crc16_step(crc, data, POLY);
  end
endmodule

// File: rtl/cil_addr_walker.sv
`timescale 1ns/1ps
module cil_addr_walker #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [7:0]        start_hi,
  input  logic [7:0]        end_hi,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam int LO_W = ADDR_W - 8;

  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      last_q <= '0;
    end else if (load) begin
      addr   <= {start_hi, {LO_W{1'b0}}};
      last_q <= {end_hi, {LO_W{1'b1}}};
    end else if (step) begin
      addr   <= addr + 1'b1;
    end
  end

  assign at_end = (addr == last_q);
endmodule

// File: rtl/cil_seq.sv
`timescale 1ns/1ps
module cil_seq import cil_pkg::*; #(
  parameter int         ATTR_BYTES = 48,
  parameter logic [7:0] MARK       = 8'hA8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_byte,
  input  logic        in_valid,
  input  logic [15:0] crc_val,
  input  logic        at_end,
  output logic        in_ready,
  output logic        take,
  output logic        crc_clear,
  output logic        crc_update,
  output logic        walk_load,
  output logic        walk_step,
  output logic [7:0]  start_hi,
  output logic        wr_en,
  output logic [15:0] wr_data,
  output logic        done,
  output logic        error,
  output logic        any_fail
);
  localparam int CNT_W = $clog2(ATTR_BYTES + 1);

  ld_state_e        state, nxt;
  logic [7:0]       segs_left;
  logic [7:0]       hi_hold;
  logic [7:0]       exp_hi;
  logic [CNT_W-1:0] attr_cnt;
  logic             hdr_fail, range_fail, sum_fail, sum_match;

  always_comb begin
    in_ready   = !(state inside {ST_WRITE, ST_DONE, ST_FAIL});
    take       = in_valid && in_ready;
    crc_update = take && (state inside {ST_RSTART, ST_REND, ST_DHI, ST_DLO, ST_ATTR});
    crc_clear  = take && (state inside {ST_GUARD, ST_CLO});
    walk_load  = take && (state == ST_REND);
    walk_step  = (state == ST_WRITE) && !at_end;
    wr_en      = (state == ST_WRITE);
    done       = (state == ST_DONE);
    error      = (state == ST_FAIL);
    sum_match  = ({exp_hi, in_byte} == crc_val);
    hdr_fail   = take && (((state == ST_MARK) && (in_byte != MARK)) ||
                          ((state == ST_GUARD) && (in_byte != ~segs_left)));
    range_fail = take && (state == ST_REND) && (in_byte < start_hi);
    sum_fail   = take && (state inside {ST_CLO, ST_ALO}) && !sum_match;
    any_fail   = hdr_fail || range_fail || sum_fail;
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_MARK:   if (take) nxt = ST_COUNT;
      ST_COUNT:  if (take) nxt = ST_GUARD;
      ST_GUARD:  if (take) nxt = (segs_left == 8'd0) ? ST_ATTR : ST_RSTART;
      ST_RSTART: if (take) nxt = ST_REND;
      ST_REND:   if (take) nxt = ST_DHI;
      ST_DHI:    if (take) nxt = ST_DLO;
      ST_DLO:    if (take) nxt = ST_WRITE;
      ST_WRITE:  nxt = at_end ? ST_CHI : ST_DHI;
      ST_CHI:    if (take) nxt = ST_CLO;
      ST_CLO:    if (take) nxt = (segs_left == 8'd1) ? ST_ATTR : ST_RSTART;
      ST_ATTR:   if (take && attr_cnt == CNT_W'(ATTR_BYTES - 1)) nxt = ST_AHI;
      ST_AHI:    if (take) nxt = ST_ALO;
      ST_ALO:    if (take) nxt = ST_DONE;
      ST_DONE:   nxt = ST_DONE;
      default:   nxt = ST_FAIL;
    endcase
    if (any_fail) nxt = ST_FAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_MARK;
      segs_left <= '0;
      hi_hold   <= '0;
      exp_hi    <= '0;
      start_hi  <= '0;
      attr_cnt  <= '0;
      wr_data   <= '0;
    end else begin
      state <= nxt;
      if (take) begin
        case (state)
          ST_COUNT:       segs_left <= in_byte;
          ST_RSTART:      start_hi  <= in_byte;
          ST_DHI:         hi_hold   <= in_byte;
          ST_DLO:         wr_data   <= {hi_hold, in_byte};
          ST_CHI, ST_AHI: exp_hi    <= in_byte;
          ST_CLO:         segs_left <= segs_left - 8'd1;
          ST_ATTR:        attr_cnt  <= attr_cnt + 1'b1;
          default: ;
        endcase
      end
      if (crc_clear) attr_cnt <= '0;
    end
  end
endmodule

// File: rtl/cart_image_loader.sv
`timescale 1ns/1ps
module cart_image_loader #(
  parameter int          ADDR_W     = 16,
  parameter int          ATTR_BYTES = 48,
  parameter logic [15:0] CRC_POLY   = 16'h1021,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF,
  parameter logic [7:0]  MARK       = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              done,
  output logic              error
);
  // Internal events, named for the checker
  logic        byte_take;
  logic        any_fail;
  logic        crc_clear, crc_update;
  logic        walk_load, walk_step, at_end;
  logic [15:0] crc_val;
  logic [7:0]  start_hi;

  cil_seq #(.ATTR_BYTES(ATTR_BYTES), .MARK(MARK)) seq_i (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .crc_val(crc_val), .at_end(at_end), .in_ready(in_ready), .take(byte_take),
    .crc_clear(crc_clear), .crc_update(crc_update), .walk_load(walk_load),
    .walk_step(walk_step), .start_hi(start_hi), .wr_en(wr_en), .wr_data(wr_data),
    .done(done), .error(error), .any_fail(any_fail)
  );

  cil_crc_unit #(.POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .update(crc_update),
    .data(in_byte), .crc(crc_val)
  );

  cil_addr_walker #(.ADDR_W(ADDR_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .step(walk_step),
    .start_hi(start_hi), .end_hi(in_byte), .addr(wr_addr), .at_end(at_end)
  );
endmodule

// File: rtl/cil_checker.sv
`timescale 1ns/1ps
module cil_checker (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic wr_en,
  input logic done,
  input logic error,
  input logic byte_take,
  input logic any_fail
);
  // R7
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !in_ready);
  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) error |=> error);
  // R6
  fail_to_err_chk: assert property (@(posedge clk) disable iff (!rst_n) any_fail |=> error);
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(error) |-> $past(byte_take));
  // R6
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && error));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> (done && !wr_en && !in_ready));
endmodule

bind cart_image_loader cil_checker chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_en(wr_en), .done(done),
  .error(error), .byte_take(byte_take), .any_fail(any_fail)
);

// File: tb/cart_image_loader_tb_top.sv
`timescale 1ns/1ps
module cart_image_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, wr_en, done, error;
  logic [15:0] wr_addr, wr_data;

  always #2.5 clk = ~clk;

  cart_image_loader dut_i (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .error(error)
  );

  int          n_chk = 0, n_fail = 0;
  int          wr_cnt = 0, ready_viol = 0;
  logic [15:0] rec_addr [0:1023];
  logic [15:0] rec_data [0:1023];
  logic [7:0]  img [$];
  logic [15:0] exp_a [$];
  bit          stalled = 0;
  bit          finished = 0;

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (wr_cnt < 1024) begin
        rec_addr[wr_cnt] = wr_addr;
        rec_data[wr_cnt] = wr_data;
      end
      wr_cnt++;
      if (in_ready) ready_viol++;
    end
  end

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + a[7:0] + 8'h11};
  endfunction

  // CRC written as a word-aligned shift register
  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    img.delete(); exp_a.delete();
    wr_cnt = 0; ready_viol = 0; stalled = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_h(input logic [7:0] b, inout logic [15:0] c);
    img.push_back(b);
    c = tb_crc(c, b);
  endtask

  task automatic add_header(input logic [7:0] cnt, input logic [7:0] mark, input logic [7:0] guard_flip);
    img.push_back(mark);
    img.push_back(cnt);
    img.push_back(~cnt ^ guard_flip);
  endtask

  task automatic add_segment(input logic [7:0] shi, input logic [7:0] ehi, input bit bad);
    logic [15:0] c, w;
    c = 16'hFFFF;
    push_h(shi, c);
    push_h(ehi, c);
    if (ehi < shi) return;
    for (int a = {16'h0, shi, 8'h00}; a <= {16'h0, ehi, 8'hFF}; a++) begin
      w = pat(a[15:0]);
      push_h(w[15:8], c);
      push_h(w[7:0], c);
      exp_a.push_back(a[15:0]);
    end
    if (bad) c = c ^ 16'h0001;
    img.push_back(c[15:8]);
    img.push_back(c[7:0]);
  endtask

  task automatic add_attr(input bit bad);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < 48; i++) push_h(8'(i * 37 + 5), c);
    if (bad) c = c ^ 16'h8000;
    img.push_back(c[15:8]);
    img.push_back(c[7:0]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    int n;
    n = 0;
    in_byte  = b;
    in_valid = 1'b1;
    while (!in_ready && n < 16) begin
      @(negedge clk);
      n++;
    end
    if (!in_ready) begin
      stalled  = 1;
      in_valid = 1'b0;
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic run_image();
    foreach (img[i]) if (!stalled) send_byte(img[i]);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic verify_writes(input string tag);
    int bad;
    bad = 0;
    check(wr_cnt == exp_a.size(), tag, "write count", wr_cnt, exp_a.size());
    for (int i = 0; i < wr_cnt && i < exp_a.size() && i < 1024; i++)
      if (rec_addr[i] != exp_a[i] || rec_data[i] != pat(rec_addr[i])) bad++;
    check(bad == 0, tag, "write address/data mismatches", bad, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    check(wr_en == 1'b0,    "R8", "wr_en after reset", wr_en, 0);
    check(done == 1'b0,     "R8", "done after reset", done, 0);
    check(error == 1'b0,    "R8", "error after reset", error, 0);
  endtask

  task automatic t_single();
    int held;
    do_reset();
    add_header(8'd1, 8'hA8, 8'h00);
    add_segment(8'h10, 8'h11, 0);
    add_attr(0);
    run_image();
    check(done == 1'b1,  "R5", "done after good image", done, 1);
    check(error == 1'b0, "R4", "no error on good CRC", error, 0);
    verify_writes("R2");
    check(ready_viol == 0, "R7", "in_ready high during write", ready_viol, 0);
    held = wr_cnt;
    in_byte = 8'h55; in_valid = 1'b1;
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R10", "in_ready after done", in_ready, 0);
    check(done == 1'b1,     "R10", "done held", done, 1);
    check(wr_cnt == held,   "R10", "writes after done", wr_cnt, held);
    in_valid = 1'b0;
  endtask

  task automatic t_multi();
    do_reset();
    add_header(8'd2, 8'hA8, 8'h00);
    add_segment(8'h20, 8'h20, 0);
    add_segment(8'hFF, 8'hFF, 0);
    add_attr(0);
    run_image();
    check(done == 1'b1, "R2", "done after two segments", done, 1);
    verify_writes("R2");
    check(ready_viol == 0, "R7", "in_ready high during write", ready_viol, 0);
  endtask

  task automatic t_zero();
    do_reset();
    add_header(8'd0, 8'hA8, 8'h00);
    add_attr(0);
    run_image();
    check(done == 1'b1, "R9", "done with no segments", done, 1);
    check(wr_cnt == 0,  "R9", "writes with no segments", wr_cnt, 0);
  endtask

  task automatic t_bad_mark();
    do_reset();
    add_header(8'd1, 8'hA7, 8'h00);
    add_segment(8'h10, 8'h10, 0);
    add_attr(0);
    run_image();
    check(error == 1'b1, "R1", "error on wrong marker", error, 1);
    check(done == 1'b0,  "R6", "done after marker fault", done, 0);
    check(stalled == 1,  "R6", "input blocked after fault", stalled, 1);
    check(wr_cnt == 0,   "R6", "writes after marker fault", wr_cnt, 0);
  endtask

  task automatic t_bad_guard();
    do_reset();
    add_header(8'd1, 8'hA8, 8'h04);
    add_segment(8'h10, 8'h10, 0);
    add_attr(0);
    run_image();
    check(error == 1'b1, "R1", "error on wrong guard byte", error, 1);
    check(wr_cnt == 0,   "R1", "writes after guard fault", wr_cnt, 0);
  endtask

  task automatic t_range();
    do_reset();
    add_header(8'd1, 8'hA8, 8'h00);
    add_segment(8'h30, 8'h2F, 0);
    for (int i = 0; i < 8; i++) img.push_back(8'h00);
    run_image();
    check(error == 1'b1, "R3", "error on reversed range", error, 1);
    check(wr_cnt == 0,   "R3", "writes for reversed range", wr_cnt, 0);
  endtask

  task automatic t_seg_crc();
    do_reset();
    add_header(8'd2, 8'hA8, 8'h00);
    add_segment(8'h40, 8'h40, 1);
    add_segment(8'h41, 8'h41, 0);
    add_attr(0);
    run_image();
    check(error == 1'b1, "R4", "error on segment CRC mismatch", error, 1);
    check(done == 1'b0,  "R6", "done after CRC fault", done, 0);
    check(wr_cnt == 256, "R6", "writes stop at faulty segment", wr_cnt, 256);
    repeat (4) @(negedge clk);
    check(error == 1'b1, "R6", "error held", error, 1);
  endtask

  task automatic t_attr_crc();
    do_reset();
    add_header(8'd1, 8'hA8, 8'h00);
    add_segment(8'h05, 8'h05, 0);
    add_attr(1);
    run_image();
    check(error == 1'b1, "R5", "error on attribute CRC mismatch", error, 1);
    check(done == 1'b0,  "R5", "done with bad attribute CRC", done, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_zero();
    t_bad_mark();
    t_bad_guard();
    t_range();
    t_seg_crc();
    t_attr_crc();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule